// File: doc/BRIEF.md
# Parallel-to-Serial Transmitter with Internal Loopback

This block turns a stream of pre-encoded 10-bit code words into a serial bit stream. It runs on a single clock at the bit rate. An internal divide-by-ten counter produces a one-cycle byte strobe, which stands in for the byte reference clock. On every strobe the word at the parallel input is captured. After a fixed pipeline delay, the captured word is shifted out one bit per clock, least significant bit first. Consecutive words follow each other with no gap.

A loopback control chooses where the stream goes. With loopback off, the stream appears on the external serial pin and the internal loop port idles at 1. With loopback on, the external pin is held at a steady 1 and the stream is routed to the loop port, which feeds the receiver's input selector. Both serial outputs are registered. The strobe is brought out so that the source of the parallel data can align to it.

Top module: `ser_loop_tx`

## Requirements
- R1: The word captured is the value on `par_in` at the rising edge that ends the cycle in which `byte_stb` is 1.
- R2: `byte_stb` is a single-cycle pulse that repeats every 10 clock cycles while reset is low.
- R3: A captured word is sent in order from bit 0 through bit 9, one bit per clock.
- R4: Bit 0 of a word captured at edge E first appears on the serial outputs just after edge E+4, which is a latency of 4 bit clocks.
- R5: Words captured on successive strobes are sent back to back, so bit 0 of the next word directly follows bit 9 of the previous one.
- R6: When `loop_en` is 0, `ser_out` carries the stream and `loop_out` is 1.
- R7: When `loop_en` is 1, `ser_out` is a constant 1 and `loop_out` carries the stream.
- R8: A change on `loop_en` takes effect on both outputs at the next rising edge, even in the middle of a word.
- R9: Synchronous reset drives `ser_out` and `loop_out` to 1 and `byte_stb` to 0, and discards any words in flight. After reset both outputs stay at 1 until the first newly captured word reaches them.
- R10: Changes on `par_in` in cycles other than the strobe cycle have no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| par_in | input | W (10) | Pre-encoded parallel code word |
| loop_en | input | 1 | 1 routes the stream to `loop_out` and parks `ser_out` at 1 |
| byte_stb | output | 1 | Byte strobe; `par_in` is captured at the edge that ends this cycle |
| ser_out | output | 1 | External serial output |
| loop_out | output | 1 | Internal loopback serial output toward the receiver |

## Verification
The bench samples on falling edges. When `byte_stb` is seen high at falling edge n, the word held at that moment is scheduled so that bit i is expected on the outputs at falling edge n+5+i. This accounts for the capture edge, the 4-edge latency and the half-cycle sampling offset. The value of `loop_en` driven at falling edge n-1 decides which output carries the bit at falling edge n, because the output register samples it one edge later. Reset clears every scheduled bit, so the outputs are expected to be 1 until the first word captured after reset arrives.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Default geometry: ten bits per code word, four bit clocks of latency.
  localparam int unsigned SER_WORD_W = 10;
  localparam int unsigned SER_LAT    = 4;
endpackage

// File: rtl/ser_byte_timer.sv
module ser_byte_timer #(
  parameter int unsigned W = ser_pkg::SER_WORD_W
) (
  input  logic clk,
  input  logic rst,
  output logic stb_o
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          stb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      stb_q <= (cnt_q == LAST);
    end
  end

  assign stb_o = stb_q;

  // R2: the strobe never lasts two cycles
  a_r2_one_wide: assert property (@(posedge clk) disable iff (rst)
    stb_q |=> !stb_q);
endmodule

// File: rtl/ser_word_latch.sv
module ser_word_latch #(
  parameter int unsigned W = ser_pkg::SER_WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (cap_i) word_q <= d_i;
  end

  assign q_o = word_q;

  a_r1_capture: assert property (@(posedge clk) disable iff (rst)
    cap_i |=> (q_o == $past(d_i)));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !cap_i |=> $stable(q_o));
endmodule

// File: rtl/ser_shift_core.sv
module ser_shift_core #(
  parameter int unsigned W   = ser_pkg::SER_WORD_W,
  parameter int unsigned LAT = ser_pkg::SER_LAT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o
);
  // The output register adds one stage, so the load trails the capture by LAT-1.
  localparam int unsigned DLY = LAT - 1;

  logic [DLY-1:0] dl_q;
  logic           load;
  logic [W-1:0]   sh_q;

  generate
    if (DLY == 1) begin : g_dly_one
      always_ff @(posedge clk) begin
        if (rst) dl_q <= '0;
        else     dl_q <= cap_i;
      end
    end else begin : g_dly_chain
      always_ff @(posedge clk) begin
        if (rst) dl_q <= '0;
        else     dl_q <= {dl_q[DLY-2:0], cap_i};
      end
    end
  endgenerate

  assign load = dl_q[DLY-1];

  // Idle value is 1: ones are shifted in behind the word.
  always_ff @(posedge clk) begin
    if (rst)       sh_q <= '1;
    else if (load) sh_q <= word_i;
    else           sh_q <= {1'b1, sh_q[W-1:1]};
  end

  assign bit_o = sh_q[0];

  a_r4_load_align: assert property (@(posedge clk) disable iff (rst)
    $past(cap_i, DLY) |-> load);
  a_r3_lsb_first: assert property (@(posedge clk) disable iff (rst)
    load |=> (bit_o == $past(word_i[0])));
  a_r5_load_once: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);
endmodule

// File: rtl/ser_path_sel.sv
module ser_path_sel (
  input  logic clk,
  input  logic rst,
  input  logic loop_en,
  input  logic bit_i,
  output logic ext_o,
  output logic lb_o
);
  logic ext_q;
  logic lb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_q <= 1'b1;
      lb_q  <= 1'b1;
    end else begin
      ext_q <= loop_en ? 1'b1  : bit_i;
      lb_q  <= loop_en ? bit_i : 1'b1;
    end
  end

  assign ext_o = ext_q;
  assign lb_o  = lb_q;

  a_r7_ext_parked: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> ext_o);
  a_r6_loop_idle: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> lb_o);
  a_r8_loop_follow: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> (lb_o == $past(bit_i)));
endmodule

// File: rtl/ser_loop_tx.sv
module ser_loop_tx #(
  parameter int unsigned W   = ser_pkg::SER_WORD_W,
  parameter int unsigned LAT = ser_pkg::SER_LAT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] par_in,
  input  logic         loop_en,
  output logic         byte_stb,
  output logic         ser_out,
  output logic         loop_out
);
  logic         stb;
  logic [W-1:0] word;
  logic         sbit;

  ser_byte_timer #(.W(W)) u_timer (
    .clk(clk), .rst(rst), .stb_o(stb)
  );

  ser_word_latch #(.W(W)) u_latch (
    .clk(clk), .rst(rst), .cap_i(stb), .d_i(par_in), .q_o(word)
  );

  ser_shift_core #(.W(W), .LAT(LAT)) u_shift (
    .clk(clk), .rst(rst), .cap_i(stb), .word_i(word), .bit_o(sbit)
  );

  ser_path_sel u_sel (
    .clk(clk), .rst(rst), .loop_en(loop_en), .bit_i(sbit),
    .ext_o(ser_out), .lb_o(loop_out)
  );

  assign byte_stb = stb;

  a_r9_reset_idle: assert property (@(posedge clk)
    rst |=> (ser_out && loop_out && !byte_stb));
endmodule

// File: tb/ser_loop_tx_test.sv
module ser_loop_tx_test;
  localparam int W     = 10;
  localparam int LAT   = 4;
  localparam int DEPTH = 2048;
  localparam int NV    = 14;

  // Stimulus vectors: {loop_en, word}. Expected bits are scheduled from R1-style rules below.
  localparam logic [W:0] VEC [NV] = '{
    {1'b0, 10'h17C}, {1'b0, 10'h283}, {1'b0, 10'h001}, {1'b0, 10'h200},
    {1'b0, 10'h3FF}, {1'b0, 10'h000}, {1'b0, 10'h2AA}, {1'b0, 10'h155},
    {1'b1, 10'h0F0}, {1'b1, 10'h30F}, {1'b1, 10'h001}, {1'b1, 10'h3FE},
    {1'b0, 10'h123}, {1'b0, 10'h2DC}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] par_in = '0;
  logic         loop_en = 1'b0;
  logic         byte_stb, ser_out, loop_out;

  ser_loop_tx #(.W(W), .LAT(LAT)) uut (
    .clk(clk), .rst(rst), .par_in(par_in), .loop_en(loop_en),
    .byte_stb(byte_stb), .ser_out(ser_out), .loop_out(loop_out)
  );

  always #4 clk = ~clk;

  int ntest = 0, nfail = 0, cyc = 0, last_stb = -1, vi = 0;
  bit stream_e [DEPTH];
  bit lp_hist  [DEPTH];
  logic [W-1:0] cur_word = '0;
  logic want_rst = 1'b1, want_loop = 1'b0;
  bit feed_en = 0, fed_pending = 0, glitch_en = 0, done = 0;

  task automatic check(input string tag, input logic got, input logic exp);
    ntest++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s cyc=%0d: got %b expected %b", tag, cyc, got, exp);
    end
  endtask

  task automatic step();
    logic rst_d, e_ext, e_lb;
    @(negedge clk);
    cyc++;
    rst_d = rst;
    if (rst_d) begin
      check("R9 ser_out in reset", ser_out, 1'b1);
      check("R9 loop_out in reset", loop_out, 1'b1);
      check("R9 byte_stb in reset", byte_stb, 1'b0);
    end else begin
      // R8: the loop_en driven one falling edge earlier picks the path
      e_ext = lp_hist[cyc-1] ? 1'b1 : stream_e[cyc];
      e_lb  = lp_hist[cyc-1] ? stream_e[cyc] : 1'b1;
      check(lp_hist[cyc-1] ? "R7 R8 ser_out parked" : "R1 R3 R4 R5 R6 R9 R10 ser_out",
            ser_out, e_ext);
      check(lp_hist[cyc-1] ? "R1 R3 R4 R5 R7 R8 loop_out" : "R6 R8 R9 loop_out idle",
            loop_out, e_lb);
    end
    // drive phase
    if (feed_en && fed_pending && vi < NV) begin
      cur_word  = VEC[vi][W-1:0];
      want_loop = VEC[vi][W];
      vi++;
    end
    fed_pending = 0;
    rst     = want_rst;
    loop_en = want_loop;
    if (glitch_en && last_stb >= 0 && (cyc - last_stb) >= 2 && (cyc - last_stb) <= 8)
      par_in = ~cur_word;   // R10: off-strobe disturbance
    else
      par_in = cur_word;
    lp_hist[cyc] = want_loop;
    // capture bookkeeping for the edge that follows
    if (rst) begin
      last_stb = -1;
      for (int k = cyc + 1; k < cyc + 20 && k < DEPTH; k++) stream_e[k] = 1'b1;
    end else if (byte_stb) begin
      if (last_stb >= 0) begin
        ntest++;
        if (cyc - last_stb != W) begin
          nfail++;
          $display("FAIL R2 strobe period: got %0d expected %0d", cyc - last_stb, W);
        end
      end
      last_stb = cyc;
      // R4: bit i visible at falling edge cyc+LAT+1+i
      for (int i = 0; i < W; i++)
        if (cyc + LAT + 1 + i < DEPTH) stream_e[cyc + LAT + 1 + i] = cur_word[i];
      fed_pending = 1;
    end
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      stream_e[k] = 1'b1;
      lp_hist[k]  = 1'b0;
    end
    // reset state (R9)
    want_rst = 1'b1;
    repeat (3) step();
    // vector table: words back to back, loop mode switching at word boundaries
    cur_word = VEC[0][W-1:0];
    want_loop = VEC[0][W];
    vi = 1;
    feed_en = 1;
    want_rst = 1'b0;
    while (vi < NV) step();
    repeat (30) step();
    feed_en = 0;
    // R10: par_in disturbed between strobes
    cur_word = 10'h2B1;
    want_loop = 1'b0;
    glitch_en = 1;
    repeat (40) step();
    glitch_en = 0;
    // R8: loop_en toggled off word boundaries
    cur_word = 10'h0C7;
    for (int t = 0; t < 30; t++) begin
      if (t % 3 == 0) want_loop = ~want_loop;
      step();
    end
    want_loop = 1'b0;
    cur_word = 10'h000;
    repeat (17) step();
    // R9: reset in the middle of a zero word drops it
    want_rst = 1'b1;
    repeat (2) step();
    want_rst = 1'b0;
    cur_word = 10'h3C5;
    repeat (40) step();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule